// File: doc/BRIEF.md
# Bit-Field Extract/Insert Unit

This execution unit serves a 32-bit processor. It recognises two immediate-form bit-field instructions and computes their result. Each cycle it takes an instruction word, the value of the source register and the present value of the destination register. It registers the result together with the decode information: whether the word is one of the two bit-field instructions, which of the two it is, whether its encoding is illegal, and the destination and source register indices.

The extract operation picks a contiguous field out of the source and returns it right-justified, with zeros above it. The insert operation takes a right-justified field from the source and writes it into a copy of the destination at a chosen bit offset. Every destination bit outside the field keeps its value. For insert, the instruction does not carry the field width. It carries the position of the field's top bit, and the unit works the width out from that position and the offset.

Top module: `bf_unit`

## Requirements
- R1: While `rst_n` is low, every output reads zero, whatever the inputs are.
- R2: The hit flag is set exactly when instr[31:26] is 6'b011001 and instr[15:14] is 01 or 10. The check uses the mask 32'hFC00C000, so all other instruction bits have no effect on it.
- R3: When there is no hit (another major opcode, or instr[15:14] equal to 00 or 11), the result, the insert flag and the illegal flag all read zero.
- R4: The insert flag is 1 exactly when there is a hit and instr[15:14] is 10. With instr[15:14] equal to 01 the operation is extract.
- R5: The destination index output always equals instr[25:21], and the source index output always equals instr[20:16].
- R6: Extract with w = instr[10:6] and s = instr[4:0] returns bits s+w-1..s of the source at bit 0, and every higher result bit is zero.
- R7: Extract with a width field of 0 returns all zeros and does not raise the illegal flag.
- R8: Insert with top position p = instr[10:6] and offset s = instr[4:0], where p ≥ s, uses width w = p − s + 1. Result bits p..s take source bits w-1..0, and all other bits equal the destination.
- R9: Insert with p = 31 and s = 0 (width 32) returns the whole source word.
- R10: Insert with p < s is illegal. The result then equals the destination unchanged and the illegal flag is 1.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| src_i | input | 32 | Source register value |
| dst_i | input | 32 | Current destination register value |
| result_o | output | 32 | Registered result word |
| hit_o | output | 1 | Instruction is a bit-field extract or insert |
| insert_o | output | 1 | 1 = insert, 0 = extract (or no hit) |
| illegal_o | output | 1 | Insert with top position below offset |
| rd_idx_o | output | 5 | Destination register index |
| rs_idx_o | output | 5 | Source register index |

## Verification
Every output is due exactly one rising edge after its inputs are presented. The bench changes inputs on a falling edge and samples on the next falling edge, which lies half a period after the capturing rising edge. One scenario changes the inputs and samples one nanosecond later, before the next rising edge, to confirm that the old result is still held. The checker's properties compare each output against `$past` of the inputs at a depth of one cycle, which is the same one-cycle offset.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SH_W   = $clog2(DATA_W);
    localparam int unsigned REG_W  = 5;

    // opcode match: top six bits plus the two selector bits
    localparam logic [DATA_W-1:0] MATCH_MASK = 32'hFC00C000;
    localparam logic [DATA_W-1:0] PAT_EXTR   = 32'h64004000;
    localparam logic [DATA_W-1:0] PAT_INSR   = 32'h64008000;

    // field positions inside the instruction word
    localparam int unsigned RD_LSB  = 21;
    localparam int unsigned RS_LSB  = 16;
    localparam int unsigned FLD_LSB = 6;
    localparam int unsigned SH_LSB  = 0;

    typedef struct packed {
        logic             hit;
        logic             ins;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs;
        logic [SH_W-1:0]  fld;
        logic [SH_W-1:0]  sh;
    } bf_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              hit;
        logic              ins;
        logic              ill;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs;
    } bf_out_t;

endpackage

// File: rtl/bf_decode.sv
module bf_decode
    import bf_pkg::*;
(
    input  logic [DATA_W-1:0] instr_i,
    output bf_dec_t           dec_o
);
    logic is_ext;
    logic is_ins;

    always_comb begin
        is_ext     = (instr_i & MATCH_MASK) == PAT_EXTR;
        is_ins     = (instr_i & MATCH_MASK) == PAT_INSR;
        dec_o.hit  = is_ext | is_ins;
        dec_o.ins  = is_ins;
        dec_o.rd   = instr_i[RD_LSB +: REG_W];
        dec_o.rs   = instr_i[RS_LSB +: REG_W];
        dec_o.fld  = instr_i[FLD_LSB +: SH_W];
        dec_o.sh   = instr_i[SH_LSB +: SH_W];
    end
endmodule

// File: rtl/bf_mask.sv
module bf_mask #(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW),
    localparam int unsigned WW = SW + 1
) (
    input  logic [WW-1:0] width_i,
    input  logic [SW-1:0] shift_i,
    output logic [DW-1:0] mask_o
);
    logic [DW:0]   ones;
    logic [DW-1:0] low;

    always_comb begin
        // one bit wider than the data so a full-width field is representable
        ones   = ({{DW{1'b0}}, 1'b1} << width_i) - {{DW{1'b0}}, 1'b1};
        low    = ones[DW-1:0];
        mask_o = low << shift_i;
    end
endmodule

// File: rtl/bf_field_alu.sv
module bf_field_alu
    import bf_pkg::*;
(
    input  bf_dec_t           dec_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ill_o
);
    localparam int unsigned WW = SH_W + 1;

    logic [WW-1:0]     ext_w;
    logic [WW-1:0]     ins_w;
    logic [DATA_W-1:0] ext_m;
    logic [DATA_W-1:0] ins_m;
    logic [DATA_W-1:0] ext_v;
    logic [DATA_W-1:0] ins_v;
    logic              bad;

    always_comb begin
        ext_w = {1'b0, dec_i.fld};
        ins_w = {1'b0, dec_i.fld} - {1'b0, dec_i.sh} + WW'(1);
        bad   = dec_i.fld < dec_i.sh;
    end

    bf_mask #(.DW(DATA_W)) u_ext_mask (
        .width_i (ext_w),
        .shift_i ({SH_W{1'b0}}),
        .mask_o  (ext_m)
    );

    bf_mask #(.DW(DATA_W)) u_ins_mask (
        .width_i (ins_w),
        .shift_i (dec_i.sh),
        .mask_o  (ins_m)
    );

    always_comb begin
        ext_v = (src_i >> dec_i.sh) & ext_m;
        ins_v = (dst_i & ~ins_m) | ((src_i << dec_i.sh) & ins_m);
        res_o = '0;
        ill_o = 1'b0;
        if (dec_i.hit) begin
            if (!dec_i.ins) begin
                res_o = ext_v;
            end else if (bad) begin
                res_o = dst_i;
                ill_o = 1'b1;
            end else begin
                res_o = ins_v;
            end
        end
    end
endmodule

// File: rtl/bf_unit.sv
module bf_unit
    import bf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] instr_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              hit_o,
    output logic              insert_o,
    output logic              illegal_o,
    output logic [REG_W-1:0]  rd_idx_o,
    output logic [REG_W-1:0]  rs_idx_o
);
    bf_dec_t           dec;
    logic [DATA_W-1:0] alu_res;
    logic              alu_ill;
    bf_out_t           out_d;
    bf_out_t           out_q;

    bf_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    bf_field_alu u_alu (
        .dec_i (dec),
        .src_i (src_i),
        .dst_i (dst_i),
        .res_o (alu_res),
        .ill_o (alu_ill)
    );

    always_comb begin
        out_d.res = alu_res;
        out_d.hit = dec.hit;
        out_d.ins = dec.hit & dec.ins;
        out_d.ill = alu_ill;
        out_d.rd  = dec.rd;
        out_d.rs  = dec.rs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o  = out_q.res;
    assign hit_o     = out_q.hit;
    assign insert_o  = out_q.ins;
    assign illegal_o = out_q.ill;
    assign rd_idx_o  = out_q.rd;
    assign rs_idx_o  = out_q.rs;
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [31:0] src_i,
    input logic [31:0] dst_i,
    input logic [31:0] result_o,
    input logic        hit_o,
    input logic        insert_o,
    input logic        illegal_o,
    input logic [4:0]  rd_idx_o,
    input logic [4:0]  rs_idx_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (result_o == 32'h0 && !hit_o && !insert_o && !illegal_o)); // R1

    AST_HIT_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hit_o) |-> $past(instr_i[31:26]) == 6'b011001); // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (result_o == 32'h0 && !insert_o && !illegal_o)); // R3

    AST_INS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && insert_o) |-> ($past(instr_i[15:14]) == 2'b10 && hit_o)); // R4

    AST_INDEX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (rd_idx_o == $past(instr_i[25:21]) && rs_idx_o == $past(instr_i[20:16]))); // R5

    AST_EXT_ZERO_W: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hit_o && !insert_o && $past(instr_i[10:6]) == 5'd0) |-> (result_o == 32'h0 && !illegal_o)); // R7

    AST_INS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && insert_o && $past(instr_i[10:6]) == 5'd31 && $past(instr_i[4:0]) == 5'd0)
        |-> result_o == $past(src_i)); // R9

    AST_ILL_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && illegal_o) |-> (insert_o && result_o == $past(dst_i))); // R10
endmodule

bind bf_unit bf_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .result_o  (result_o),
    .hit_o     (hit_o),
    .insert_o  (insert_o),
    .illegal_o (illegal_o),
    .rd_idx_o  (rd_idx_o),
    .rs_idx_o  (rs_idx_o)
);

// File: tb/tb_bf_unit.sv
module tb_bf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] result_o;
    logic        hit_o, insert_o, illegal_o;
    logic [4:0]  rd_idx_o, rs_idx_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bf_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .src_i(src_i), .dst_i(dst_i),
        .result_o(result_o), .hit_o(hit_o), .insert_o(insert_o), .illegal_o(illegal_o),
        .rd_idx_o(rd_idx_o), .rs_idx_o(rs_idx_o)
    );

    function automatic logic [31:0] enc(input logic [1:0] sel, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] f,
                                        input logic [4:0] s);
        return {6'b011001, rd, rs, sel, 3'b000, f, 1'b0, s};
    endfunction

    function automatic logic [31:0] ref_ext(input logic [31:0] v, input int w, input int s);
        logic [63:0] m = (64'd1 << w) - 64'd1;
        return (v >> s) & m[31:0];
    endfunction

    function automatic logic [31:0] ref_ins(input logic [31:0] v, input logic [31:0] d,
                                            input int w, input int s);
        logic [63:0] m = ((64'd1 << w) - 64'd1) << s;
        return (d & ~m[31:0]) | ((v << s) & m[31:0]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        instr_i = i; src_i = s; dst_i = d;
        @(negedge clk);
    endtask

    task automatic t_reset();
        instr_i = enc(2'b10, 5'd3, 5'd4, 5'd31, 5'd0);
        src_i = 32'hFFFF_FFFF; dst_i = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 result", result_o, 32'h0);
        chk("R1 flags", {29'd0, hit_o, insert_o, illegal_o}, 32'h0);
        chk("R1 idx", {22'd0, rd_idx_o, rs_idx_o}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_decode();
        // R2: extra bits outside the match mask do not matter
        drive(enc(2'b01, 5'd7, 5'd9, 5'd8, 5'd4) | 32'h0000_3820, 32'hABCD_EF01, 32'h0);
        chk("R2 hit", {31'd0, hit_o}, 32'd1);
        chk("R4 extract sel", {31'd0, insert_o}, 32'd0);
        chk("R5 rd", {27'd0, rd_idx_o}, 32'd7);
        chk("R5 rs", {27'd0, rs_idx_o}, 32'd9);
        drive(enc(2'b10, 5'd1, 5'd2, 5'd7, 5'd0), 32'hFF, 32'h0);
        chk("R4 insert sel", {31'd0, insert_o}, 32'd1);
        for (int sel = 0; sel < 4; sel += 3) begin
            drive(enc(2'(sel), 5'd30, 5'd17, 5'd8, 5'd4), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            chk("R3 sel miss hit", {31'd0, hit_o}, 32'd0);
            chk("R3 sel miss result", result_o, 32'h0);
            chk("R3 sel miss flags", {30'd0, insert_o, illegal_o}, 32'h0);
            chk("R5 rd on miss", {27'd0, rd_idx_o}, 32'd30);
        end
        drive(enc(2'b01, 5'd1, 5'd1, 5'd8, 5'd0) ^ 32'h0400_0000, 32'hFFFF_FFFF, 32'h5);
        chk("R3 opcode miss hit", {31'd0, hit_o}, 32'd0);
        chk("R3 opcode miss result", result_o, 32'h0);
    endtask

    task automatic t_extract_sweep();
        for (int w = 1; w <= 31; w++) begin
            for (int s = 0; s + w <= 32; s++) begin
                logic [31:0] v = $urandom;
                drive(enc(2'b01, 5'd2, 5'd3, 5'(w), 5'(s)), v, $urandom);
                chk($sformatf("R6 ext w=%0d s=%0d", w, s), result_o, ref_ext(v, w, s));
            end
        end
        drive(enc(2'b01, 5'd2, 5'd3, 5'd0, 5'd5), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R7 ext width 0", result_o, 32'h0);
        chk("R7 no illegal", {31'd0, illegal_o}, 32'd0);
        drive(enc(2'b01, 5'd2, 5'd3, 5'd1, 5'd31), 32'h8000_0000, 32'h0);
        chk("R6 ext w1 s31", result_o, 32'h1);
    endtask

    task automatic t_insert_sweep();
        for (int w = 1; w <= 32; w++) begin
            for (int s = 0; s + w <= 32; s++) begin
                logic [31:0] v = $urandom;
                logic [31:0] d = $urandom;
                drive(enc(2'b10, 5'd4, 5'd5, 5'(w + s - 1), 5'(s)), v, d);
                chk($sformatf("R8 ins w=%0d s=%0d", w, s), result_o, ref_ins(v, d, w, s));
            end
        end
        drive(enc(2'b10, 5'd4, 5'd5, 5'd31, 5'd0), 32'hDEAD_BEEF, 32'h0123_4567);
        chk("R9 full replace", result_o, 32'hDEAD_BEEF);
        drive(enc(2'b10, 5'd4, 5'd5, 5'd31, 5'd31), 32'h0000_0001, 32'h0000_0000);
        chk("R8 ins w1 s31", result_o, 32'h8000_0000);
    endtask

    task automatic t_illegal();
        drive(enc(2'b10, 5'd4, 5'd5, 5'd3, 5'd9), 32'hFFFF_FFFF, 32'hCAFE_F00D);
        chk("R10 keeps dst", result_o, 32'hCAFE_F00D);
        chk("R10 illegal flag", {31'd0, illegal_o}, 32'd1);
        drive(enc(2'b10, 5'd4, 5'd5, 5'd9, 5'd9), 32'h1, 32'h0);
        chk("R10 p==s legal", {31'd0, illegal_o}, 32'd0);
        chk("R8 p==s single bit", result_o, 32'h0000_0200);
    endtask

    task automatic t_latency();
        drive(enc(2'b01, 5'd1, 5'd2, 5'd8, 5'd0), 32'h0000_00A5, 32'h0);
        instr_i = enc(2'b01, 5'd1, 5'd2, 5'd8, 5'd8);
        src_i   = 32'h0000_3C00;
        #1;
        chk("R11 holds old", result_o, 32'h0000_00A5);
        @(negedge clk);
        chk("R11 new after edge", result_o, 32'h0000_003C);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_extract_sweep();
        t_insert_sweep();
        t_illegal();
        t_latency();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule